// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the eight input pins of a general-purpose I/O port and raises one interrupt request when a selected condition appears on any pin that software has unmasked. Each pin has its own choice of trigger: a high or low level, a rising or falling edge, or a transition in either direction. Pin levels are first brought into the clock domain through a two-flop synchroniser. Edges are found by comparing the current synchronised sample with the sample from the cycle before.

Each pin owns a two-state machine. In `PIN_QUIET` the pin has nothing to report. It moves to `PIN_PENDING` on its trigger. For an edge, that is the trigger edge. For a level, that is the matching level. An edge-triggered pin leaves `PIN_PENDING` only through a write-one-to-clear. A clear that lands in the same cycle as a new edge is lost, and the pin stays pending. A level-triggered pin leaves `PIN_PENDING` only when its synchronised level no longer matches, and it ignores clears. The raw status is the set of pending pins. The masked status is the raw status gated by the mask, and the interrupt output is the OR of the masked status bits.

Software reaches the configuration and status through a small register bus. A write is captured on the rising clock edge when `bus_wen` is high. A read is combinational from `bus_addr`.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, the registers at offsets 0x404, 0x408, 0x40C, 0x410, 0x414, 0x418 and 0x41C all read 0, and `irq_out` is low.
- R2: The trigger-type register (0x404), the any-edge register (0x408), the polarity register (0x40C) and the mask register (0x410) read back the last value written. In every register, bit i belongs to pin i.
- R3: With the trigger-type bit at 0 (edge) and the any-edge bit at 0, a polarity bit of 1 latches rising edges only and a polarity bit of 0 latches falling edges only. If a pin changes just before rising edge k, its raw status bit (0x414) reads 1 after edge k+2.
- R4: With the trigger-type bit at 0 and the any-edge bit at 1, both rising and falling edges latch the raw bit, whatever the polarity bit holds.
- R5: With the trigger-type bit at 1 (level), the raw bit is 1 while the synchronised pin matches the polarity bit (1 = high, 0 = low). It returns to 0 two cycles after the pin stops matching. Writing 1 to its clear bit has no effect while the level still matches.
- R6: Writing 1 to bit i of 0x41C clears a latched edge event on pin i, starting the cycle after the write. Writing 0 leaves the bit as it is. Offset 0x41C always reads 0.
- R7: If a clear for pin i is captured on the same clock edge that a new trigger edge is latched for pin i, the raw bit stays 1.
- R8: Offset 0x418 reads raw status AND mask. `irq_out` is 1 exactly when that value is non-zero.
- R9: Writes to 0x414 and 0x418 have no effect.
- R10: A latched edge event stays set after the pin returns to its former level, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pin_in | input | NPINS (8) | Asynchronous pin levels |
| bus_addr | input | 12 | Register byte offset |
| bus_wen | input | 1 | Write strobe, captured on the rising clock edge |
| bus_wdata | input | NPINS (8) | Write data |
| bus_rdata | output | NPINS (8) | Combinational read data for `bus_addr` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A pin change driven just before clock edge k passes through two synchroniser flops and the previous-sample flop. It becomes visible in the raw and masked status and on `irq_out` after edge k+2, so the bench waits three falling edges after every pin change before it reads. A register write, or a clear, is captured on the next rising edge and shows on the following read. The test for R7 therefore places the clear write two falling edges after the pin change, so that the clear and the edge meet on edge k+2. Level tests read only after both the synchroniser and the status flop have settled.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_SENSE  = 12'h404;
    localparam logic [ADDR_W-1:0] OFS_ANYEDG = 12'h408;
    localparam logic [ADDR_W-1:0] OFS_POLAR  = 12'h40C;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h410;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_MSKD   = 12'h418;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h41C;

    typedef enum logic {
        PIN_QUIET   = 1'b0,
        PIN_PENDING = 1'b1
    } pin_state_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic sense,
    input  logic any_edge,
    input  logic polar,
    input  logic clr,
    output logic raw
);
    pin_state_e state_q;
    pin_state_e state_d;
    logic       prev_q;
    logic       rise;
    logic       fall;
    logic       edge_hit;
    logic       level_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl;
        end
    end

    always_comb begin
        rise      = lvl & ~prev_q;
        fall      = ~lvl & prev_q;
        edge_hit  = any_edge ? (rise | fall) : (polar ? rise : fall);
        level_hit = polar ? lvl : ~lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_QUIET: begin
                if (sense ? level_hit : edge_hit) begin
                    state_d = PIN_PENDING;
                end
            end
            PIN_PENDING: begin
                if (sense) begin
                    if (!level_hit) begin
                        state_d = PIN_QUIET;
                    end
                end else if (clr && !edge_hit) begin
                    state_d = PIN_QUIET;
                end
            end
        endcase
    end

    always_comb begin
        raw = (state_q == PIN_PENDING);
    end

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense && edge_hit && clr) |=> raw); // R7
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sense && level_hit) |=> raw); // R5
    AST_LEVEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sense && !level_hit) |=> !raw); // R5
    AST_EDGE_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense && raw && !clr) |=> raw); // R10
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic [NPINS-1:0]  raw_vec,
    input  logic [NPINS-1:0]  mskd_vec,
    output logic [NPINS-1:0]  bus_rdata,
    output logic [NPINS-1:0]  sense_q,
    output logic [NPINS-1:0]  anyedg_q,
    output logic [NPINS-1:0]  polar_q,
    output logic [NPINS-1:0]  mask_q,
    output logic [NPINS-1:0]  clr_pulse
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q  <= '0;
            anyedg_q <= '0;
            polar_q  <= '0;
            mask_q   <= '0;
        end else if (bus_wen) begin
            if (bus_addr == OFS_SENSE)  sense_q  <= bus_wdata;
            if (bus_addr == OFS_ANYEDG) anyedg_q <= bus_wdata;
            if (bus_addr == OFS_POLAR)  polar_q  <= bus_wdata;
            if (bus_addr == OFS_MASK)   mask_q   <= bus_wdata;
        end
    end

    always_comb begin
        clr_pulse = (bus_wen && bus_addr == OFS_CLEAR) ? bus_wdata : '0;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_SENSE:  bus_rdata = sense_q;
            OFS_ANYEDG: bus_rdata = anyedg_q;
            OFS_POLAR:  bus_rdata = polar_q;
            OFS_MASK:   bus_rdata = mask_q;
            OFS_RAW:    bus_rdata = raw_vec;
            OFS_MSKD:   bus_rdata = mskd_vec;
            default:    bus_rdata = '0;
        endcase
    end

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == OFS_MASK) |=> (mask_q == $past(bus_wdata))); // R2
    AST_SENSE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == OFS_SENSE) |=> (sense_q == $past(bus_wdata))); // R2
    AST_CFG_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && (bus_addr == OFS_RAW || bus_addr == OFS_MSKD)) |=> $stable(mask_q)); // R9
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    output logic              irq_out
);
    logic [NPINS-1:0] pin_s;
    logic [NPINS-1:0] raw_vec;
    logic [NPINS-1:0] mskd_vec;
    logic [NPINS-1:0] sense_q;
    logic [NPINS-1:0] anyedg_q;
    logic [NPINS-1:0] polar_q;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] clr_pulse;

    gpio_irq_sync #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pin_s)
    );

    gpio_irq_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .raw_vec   (raw_vec),
        .mskd_vec  (mskd_vec),
        .bus_rdata (bus_rdata),
        .sense_q   (sense_q),
        .anyedg_q  (anyedg_q),
        .polar_q   (polar_q),
        .mask_q    (mask_q),
        .clr_pulse (clr_pulse)
    );

    for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
        gpio_irq_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (pin_s[gi]),
            .sense    (sense_q[gi]),
            .any_edge (anyedg_q[gi]),
            .polar    (polar_q[gi]),
            .clr      (clr_pulse[gi]),
            .raw      (raw_vec[gi])
        );
    end

    always_comb begin
        mskd_vec = raw_vec & mask_q;
        irq_out  = |mskd_vec;
    end

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_out); // R8
    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (raw_vec != '0)); // R8
endmodule

// File: tb/test_gpio_irq_detect.sv
`timescale 1ns/1ps
module test_gpio_irq_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_in = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [11:0] A_SENSE = 12'h404, A_ANY = 12'h408, A_POL = 12'h40C,
                            A_MASK = 12'h410, A_RAW = 12'h414, A_MSKD = 12'h418,
                            A_CLR = 12'h41C;

    // fields: sense, anyedge, polarity, mask, pins before, pins after, expected raw
    localparam int NVEC = 6;
    localparam logic [55:0] VEC [NVEC] = '{
        56'h00_00_FF_FF_00_0F_0F,
        56'h00_00_00_FF_FF_F0_0F,
        56'h00_00_FF_FF_FF_00_00,
        56'h00_FF_00_FF_0F_3C_33,
        56'hFF_00_F0_FF_00_A5_AA,
        56'hF0_0C_A0_0F_00_FF_AC
    };

    gpio_irq_detect i_gpio_irq_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic string vtag(int i);
        case (i)
            3: return "R4";
            4: return "R5";
            5: return "R3/R4/R5 mixed";
            default: return "R3";
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic setpins(logic [7:0] p, int wait_cyc);
        @(negedge clk);
        pin_in = p;
        repeat (wait_cyc) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(A_SENSE, v); check("R1 sense", v, 8'h00);
        rd(A_ANY, v);   check("R1 anyedge", v, 8'h00);
        rd(A_POL, v);   check("R1 polarity", v, 8'h00);
        rd(A_MASK, v);  check("R1 mask", v, 8'h00);
        rd(A_RAW, v);   check("R1 raw", v, 8'h00);
        rd(A_MSKD, v);  check("R1 masked", v, 8'h00);
        rd(A_CLR, v);   check("R1 clear", v, 8'h00);
        check("R1 irq", {7'd0, irq_out}, 8'h00);

        // R2: readback
        wr(A_SENSE, 8'h5A); rd(A_SENSE, v); check("R2 sense", v, 8'h5A);
        wr(A_ANY, 8'hC3);   rd(A_ANY, v);   check("R2 anyedge", v, 8'hC3);
        wr(A_POL, 8'h96);   rd(A_POL, v);   check("R2 polarity", v, 8'h96);
        wr(A_MASK, 8'h3E);  rd(A_MASK, v);  check("R2 mask", v, 8'h3E);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            wr(A_SENSE, VEC[i][55:48]);
            wr(A_ANY,   VEC[i][47:40]);
            wr(A_POL,   VEC[i][39:32]);
            wr(A_MASK,  VEC[i][31:24]);
            setpins(VEC[i][23:16], 4);
            wr(A_CLR, 8'hFF);
            setpins(VEC[i][15:8], 3);
            exp = VEC[i][7:0];
            rd(A_RAW, v);  check(vtag(i), v, exp);
            rd(A_MSKD, v); check("R8 masked", v, exp & VEC[i][31:24]);
            check("R8 irq", {7'd0, irq_out}, {7'd0, |(exp & VEC[i][31:24])});
        end

        // R10 / R9 / R6 on pin 0, rising edge, mask off
        wr(A_SENSE, 8'h00); wr(A_ANY, 8'h00); wr(A_POL, 8'h01); wr(A_MASK, 8'h00);
        setpins(8'h00, 4);
        wr(A_CLR, 8'hFF);
        setpins(8'h01, 3);
        setpins(8'h00, 5);
        rd(A_RAW, v);  check("R10 latch held", v, 8'h01);
        check("R8 irq masked off", {7'd0, irq_out}, 8'h00);
        wr(A_RAW, 8'hFF); wr(A_MSKD, 8'hFF);
        rd(A_RAW, v);  check("R9 raw write ignored", v, 8'h01);
        rd(A_MSKD, v); check("R9 masked write ignored", v, 8'h00);
        rd(A_MASK, v); check("R9 mask untouched", v, 8'h00);
        wr(A_CLR, 8'h00);
        rd(A_RAW, v);  check("R6 clear zero keeps", v, 8'h01);
        rd(A_CLR, v);  check("R6 clear reads zero", v, 8'h00);
        wr(A_CLR, 8'h01);
        rd(A_RAW, v);  check("R6 clear one", v, 8'h00);

        // R5: level high on pin 0, clear ignored while asserted
        wr(A_SENSE, 8'h01); wr(A_MASK, 8'h01);
        setpins(8'h01, 4);
        rd(A_RAW, v);  check("R5 level set", v, 8'h01);
        wr(A_CLR, 8'h01);
        rd(A_RAW, v);  check("R5 clear ignored", v, 8'h01);
        check("R8 irq level", {7'd0, irq_out}, 8'h01);
        setpins(8'h00, 3);
        rd(A_RAW, v);  check("R5 level drop", v, 8'h00);
        check("R8 irq drop", {7'd0, irq_out}, 8'h00);

        // R7: any-edge on pin 0, clear collides with a new edge
        wr(A_SENSE, 8'h00); wr(A_ANY, 8'h01);
        wr(A_CLR, 8'hFF);
        setpins(8'h01, 3);
        rd(A_RAW, v);  check("R4 rise latched", v, 8'h01);
        @(negedge clk);
        pin_in = 8'h00;
        @(negedge clk);
        wr(A_CLR, 8'h01);
        rd(A_RAW, v);  check("R7 edge beats clear", v, 8'h01);
        wr(A_CLR, 8'h01);
        rd(A_RAW, v);  check("R6 later clear", v, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule